// File: doc/BRIEF.md
# Modulo-258114 Adder

This block adds two 18-bit residues and returns their sum reduced modulo 258114, a modulus that sits just under the 18-bit word range. Since the modulus is neither a power of two nor one away from one, the end-around carry trick does not apply. The block instead forms the plain sum and, in the same clock period, adds the constant 4030 (2^18 minus the modulus) to it. The carry out of that second, corrected sum tells whether the plain sum reached the modulus, and it selects which of the two sums is kept.

Both operands are latched into an operand register on a valid strobe, so the arithmetic sees only stable values. The chained adders and the select are purely combinational between the operand register and a result register. A result and its valid strobe therefore appear one clock after the operands are accepted, and the block can accept a new operand pair every cycle. Operands are expected to already be below the modulus; for other inputs the result is unspecified.

Top module: `mod_adder`

## Requirements
- R1: While rst_ni is low, and after it rises until the first accepted operands have produced a result, out_vld_o is 0 and sum_o is 0.
- R2: For operands opa_i, opb_i both below 258114, the result on sum_o equals (opa_i + opb_i) mod 258114 and is always below 258114.
- R3: A plain sum from 258114 up to 262143, which gives no carry out of 18 bits, is still reduced: sum_o = plain sum − 258114.
- R4: A plain sum of 262144 or more (carry out of 18 bits) is reduced: sum_o = plain sum − 258114, up to the largest sum 516226 giving 258112.
- R5: A plain sum below 258114 is passed to sum_o unchanged.
- R6: Operands presented with in_vld_i = 1 before rising edge k are captured at edge k; out_vld_o is 1 and sum_o holds their result after edge k+1, and out_vld_o is 0 after edge k+1 if in_vld_i was 0 before edge k.
- R7: While in_vld_i is 0, changes on opa_i and opb_i have no effect: sum_o keeps its last result and out_vld_o stays 0.
- R8: Operand values changed with in_vld_i = 0 in the cycle after a pair was accepted do not alter the result of that accepted pair.
- R9: With in_vld_i held at 1 on consecutive cycles, one correct result per cycle comes out in input order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 1 | Operand pair valid; operands are captured on this cycle's edge |
| opa_i | input | 18 | First operand, below 258114 |
| opb_i | input | 18 | Second operand, below 258114 |
| out_vld_o | output | 1 | Result valid, one cycle after capture |
| sum_o | output | 18 | (opa + opb) mod 258114 |

## Verification
The only internal state is the operand register and the result register, so any error shows at the ports no later than the edge after the operands are captured. A wrong wrap decision shows as a result off by exactly 258114 (or 4030 in the low 18 bits), which the boundary sums 258113, 258114, 262143, 262144 and 516226 expose directly. A register that fails to hold, or that samples operands while the strobe is low, shows as a changed sum_o during idle cycles or a wrong value for an accepted pair whose inputs moved afterwards.

// File: rtl/mod_adder_pkg.sv
package mod_adder_pkg;
  localparam int unsigned DEF_WIDTH   = 18;
  localparam int unsigned DEF_MODULUS = 258114;

  // correction that lifts a sum at or above the modulus past 2^width
  function automatic int unsigned wrap_corr(input int unsigned width, input int unsigned modulus);
    return (32'd1 << width) - modulus;
  endfunction
endpackage

// File: rtl/mod_adder_opnd_reg.sv
module mod_adder_opnd_reg #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             vld_o,
  output logic [WIDTH-1:0] a_o,
  output logic [WIDTH-1:0] b_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      a_o   <= '0;
      b_o   <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        a_o <= a_i;
        b_o <= b_i;
      end
    end
  end
endmodule

// File: rtl/mod_adder_core.sv
module mod_adder_core
  import mod_adder_pkg::*;
#(
  parameter int unsigned WIDTH   = 18,
  parameter int unsigned MODULUS = 258114
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             wrap_o
);
  localparam logic [WIDTH:0] CORR = (WIDTH+1)'(wrap_corr(WIDTH, MODULUS));

  logic [WIDTH:0] raw_sum;
  logic [WIDTH:0] adj_sum;

  // both adders chained in one period; bit WIDTH of adj_sum <=> raw_sum >= MODULUS
  assign raw_sum = {1'b0, a_i} + {1'b0, b_i};
  assign adj_sum = raw_sum + CORR;
  assign wrap_o  = adj_sum[WIDTH];
  assign sum_o   = wrap_o ? adj_sum[WIDTH-1:0] : raw_sum[WIDTH-1:0];
endmodule

// File: rtl/mod_adder_res_reg.sv
module mod_adder_res_reg #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [WIDTH-1:0] sum_i,
  output logic             vld_o,
  output logic [WIDTH-1:0] sum_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      sum_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) sum_o <= sum_i;
    end
  end
endmodule

// File: rtl/mod_adder.sv
module mod_adder
  import mod_adder_pkg::*;
#(
  parameter int unsigned WIDTH   = DEF_WIDTH,
  parameter int unsigned MODULUS = DEF_MODULUS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_vld_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  output logic             out_vld_o,
  output logic [WIDTH-1:0] sum_o
);
  logic             opnd_vld_q;
  logic [WIDTH-1:0] opa_q;
  logic [WIDTH-1:0] opb_q;
  logic [WIDTH-1:0] mod_sum;
  logic             wrap;

  mod_adder_opnd_reg #(.WIDTH(WIDTH)) u_opnd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (in_vld_i),
    .a_i   (opa_i),
    .b_i   (opb_i),
    .vld_o (opnd_vld_q),
    .a_o   (opa_q),
    .b_o   (opb_q)
  );

  mod_adder_core #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_core (
    .a_i   (opa_q),
    .b_i   (opb_q),
    .sum_o (mod_sum),
    .wrap_o(wrap)
  );

  mod_adder_res_reg #(.WIDTH(WIDTH)) u_res (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (opnd_vld_q),
    .sum_i (mod_sum),
    .vld_o (out_vld_o),
    .sum_o (sum_o)
  );
endmodule

// File: rtl/mod_adder_chk.sv
module mod_adder_chk #(
  parameter int unsigned WIDTH   = 18,
  parameter int unsigned MODULUS = 258114
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_vld_i,
  input logic             out_vld_o,
  input logic [WIDTH-1:0] sum_o,
  input logic             opnd_vld_q,
  input logic [WIDTH-1:0] opa_q,
  input logic [WIDTH-1:0] opb_q,
  input logic             wrap
);
  localparam logic [WIDTH-1:0] MOD_W = WIDTH'(MODULUS);
  localparam logic [WIDTH:0]   MOD_X = (WIDTH+1)'(MODULUS);

  logic [WIDTH:0] ref_raw;
  assign ref_raw = {1'b0, opa_q} + {1'b0, opb_q};

  p_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> (sum_o < MOD_W));

  // R3 and R4: any plain sum at or above the modulus is reduced
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opnd_vld_q && ref_raw >= MOD_X) |=> ({1'b0, sum_o} == $past(ref_raw) - MOD_X));

  p_wrap_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opnd_vld_q |-> (wrap == (ref_raw >= MOD_X)));

  p_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opnd_vld_q && ref_raw < MOD_X) |=> ({1'b0, sum_o} == $past(ref_raw)));

  p_lat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_vld_i |=> ##1 out_vld_o);

  p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_vld_i |=> ##1 (!out_vld_o && $stable(sum_o)));
endmodule

bind mod_adder mod_adder_chk #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .in_vld_i  (in_vld_i),
  .out_vld_o (out_vld_o),
  .sum_o     (sum_o),
  .opnd_vld_q(opnd_vld_q),
  .opa_q     (opa_q),
  .opb_q     (opb_q),
  .wrap      (wrap)
);

// File: tb/mod_adder_bench.sv
module mod_adder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 18;
  localparam int M = 258114;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_vld_i = 1'b0;
  logic [W-1:0] opa_i = '0;
  logic [W-1:0] opb_i = '0;
  logic         out_vld_o;
  logic [W-1:0] sum_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mod_adder u_mod_adder (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .in_vld_i (in_vld_i),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .out_vld_o(out_vld_o),
    .sum_o    (sum_o)
  );

  function automatic int ref_mod(input int a, input int b);
    return (a + b) % M;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one pair, idle one cycle with scrambled operands, check result
  task automatic t_pair(input string req, input int a, input int b);
    @(negedge clk_i);
    in_vld_i = 1'b1; opa_i = W'(a); opb_i = W'(b);
    @(negedge clk_i);
    in_vld_i = 1'b0; opa_i = ~opa_i; opb_i = W'(b + 7);
    @(negedge clk_i);
    chk({req, " vld"}, int'(out_vld_o), 1);
    chk(req, int'(sum_o), ref_mod(a, b));
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R1 vld in reset", int'(out_vld_o), 0);
    chk("R1 sum in reset", int'(sum_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 vld after reset", int'(out_vld_o), 0);
    chk("R1 sum after reset", int'(sum_o), 0);
  endtask

  task automatic t_boundaries();
    t_pair("R5 sum 0", 0, 0);
    t_pair("R5 sum M-1", M - 1, 0);
    t_pair("R3 sum M", M - 1, 1);
    t_pair("R3 sum 2^18-1", M - 1, 4030);
    t_pair("R4 sum 2^18", M - 1, 4031);
    t_pair("R4 sum 2M-2", M - 1, M - 1);
    t_pair("R3 sum M mid", 129057, 129057);
  endtask

  task automatic t_hold();
    int held;
    t_pair("R7 seed", 1000, 2345);
    held = int'(sum_o);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      opa_i = W'(i * 5003); opb_i = W'(M - 1 - i);
      chk("R7 idle vld", int'(out_vld_o), 0);
      chk("R7 idle sum", int'(sum_o), held);
    end
  endtask

  task automatic t_inflight();
    // t_pair changes the inputs in the cycle after capture
    t_pair("R8 moved inputs", 200000, 100000);
    t_pair("R8 moved inputs low", 17, 3);
  endtask

  task automatic t_stream();
    int ea [8];
    int eb [8];
    for (int i = 0; i < 8; i++) begin
      ea[i] = (i * 37123 + 250000) % M;
      eb[i] = (i * 91011 + 4000) % M;
    end
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      if (i >= 2) begin
        chk("R9 stream vld", int'(out_vld_o), 1);
        chk("R9 stream sum", int'(sum_o), ref_mod(ea[i-2], eb[i-2]));
      end
      if (i < 8) begin
        in_vld_i = 1'b1; opa_i = W'(ea[i]); opb_i = W'(eb[i]);
      end else begin
        in_vld_i = 1'b0;
      end
    end
    @(negedge clk_i);
    chk("R6 vld drops", int'(out_vld_o), 0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 200; i++) begin
      int a;
      int b;
      a = int'($urandom % M);
      b = int'($urandom % M);
      t_pair("R2 random", a, b);
    end
  endtask

  task automatic t_reset_mid();
    t_pair("R6 pre-reset", 5, 6);
    t_reset();
  endtask

  initial begin
    t_reset();
    t_boundaries();
    t_hold();
    t_inflight();
    t_stream();
    t_random();
    t_reset_mid();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule